// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Mailbox

This block lets software running on several cores signal one another. Each core owns a small first-in first-out queue of interrupt numbers and one level interrupt line. Any core posts an interrupt number through a shared register bus, either to one chosen core or to all cores except a chosen one. The chosen core's line stays high while its queue holds anything.

A core collects its interrupts by reading a shared receive register. The requester-ID sideband on the bus tells the block whose queue to pop. An empty queue reads as zero, so zero is reserved and never used as a real interrupt number. A core that writes the receive register throws away everything pending for it. When a queue is full, a new post to it is dropped and a sticky per-core overflow bit records the loss. A read of the status register returns those bits and clears them.

Posts pass through one register stage before they reach the queues. A post and a pop can therefore land on the same queue in the same cycle, and both take effect.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every interrupt line is low, no read response is valid, and every queue is empty.
- R2: A write to register 0 (send-one) carries the interrupt number in bits 31:16 and the target core index in bits 15:0. It appends the number only to the target's queue. The target's line is high after the second rising edge following the write.
- R3: A write to register 1 (send-except) uses the same data layout. It appends the number to the queue of every core other than the named one.
- R4: A target index of N_CORES or above names no core. A send-one with such an index changes nothing, and a send-except with such an index reaches all cores.
- R5: A read of register 2 (receive) by core c produces a response one cycle later, with bus_rvalid high. The data is the oldest entry of queue c, zero-extended, and that entry is removed, so entries come out in posting order.
- R6: A receive read by a core whose queue is empty returns 0.
- R7: A write to register 2 by core c empties queue c and drops line c on the next edge. The other queues are untouched.
- R8: Line c is high exactly while queue c holds at least one entry, and it falls on the edge that removes the last one.
- R9: Each queue holds QUEUE_DEPTH entries (8 by default). A post to a full queue is dropped, the existing entries are kept, and overflow bit c is set.
- R10: A read of register 3 (status) returns overflow bit c in data bit c, with all higher bits zero, and clears every overflow bit.
- R11: When a post and a receive read reach the same queue in the same cycle, both take effect: the count is unchanged, and on a full queue the post is accepted without setting overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 send-one, 1 send-except, 2 receive, 3 status |
| bus_wdata | input | 32 | Write data: [31:16] interrupt number, [15:0] target core |
| bus_core | input | CORE_ID_W | Index of the requesting core |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| irq | output | N_CORES | Per-core level interrupt, high while that core's queue is non-empty |

## Verification
The assertions assume at most one access per cycle. They also assume that bus_core always names an existing core, so the line indexed by the requester is defined. The bench keeps to this by driving a single access per cycle from tasks, with the requester index limited to 0..3. Only the target field in the write data goes out of range, and those values exercise R4. Interrupt number zero is never posted, so a zero read can only mean an empty queue.

// File: rtl/ipi_mailbox_pkg.sv
package ipi_mailbox_pkg;

    localparam int WORD_W     = 32;
    localparam int VEC_W      = 16;
    localparam int TGT_W      = 16;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_SEND_ONE    = 2'd0,
        REG_SEND_EXCEPT = 2'd1,
        REG_RECV        = 2'd2,
        REG_OVF         = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ipi_post_decode.sv
module ipi_post_decode
    import ipi_mailbox_pkg::*;
#(
    parameter int N_CORES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0]     wdata,
    output logic [N_CORES-1:0]    push_mask,
    output logic [VEC_W-1:0]      push_vec
);

    typedef struct packed {
        logic [N_CORES-1:0] mask;
        logic [VEC_W-1:0]   vec;
    } post_t;

    post_t post_d, post_q;
    logic [TGT_W-1:0] tgt;

    assign tgt = wdata[TGT_W-1:0];

    always_comb begin
        post_d      = post_q;
        post_d.mask = '0;
        if (req && we) begin
            unique case (reg_sel_e'(addr))
                REG_SEND_ONE: begin
                    post_d.vec = wdata[WORD_W-1 -: VEC_W];
                    for (int i = 0; i < N_CORES; i++) begin
                        post_d.mask[i] = (tgt == TGT_W'(i));
                    end
                end
                REG_SEND_EXCEPT: begin
                    post_d.vec = wdata[WORD_W-1 -: VEC_W];
                    for (int i = 0; i < N_CORES; i++) begin
                        post_d.mask[i] = (tgt != TGT_W'(i));
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) post_q <= '0;
        else        post_q <= post_d;
    end

    assign push_mask = post_q.mask;
    assign push_vec  = post_q.vec;

endmodule

// File: rtl/ipi_fifo.sv
module ipi_fifo
    import ipi_mailbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [VEC_W-1:0] push_vec,
    input  logic             pop,
    input  logic             flush,
    output logic [VEC_W-1:0] head_vec,
    output logic             busy,
    output logic             drop
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][VEC_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
        logic                        busy;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  popped;

    always_comb begin
        fifo_d = fifo_q;
        popped = 1'b0;
        drop   = 1'b0;
        if (flush) begin
            fifo_d.cnt = '0;
            fifo_d.rd  = fifo_q.wr;
        end else if (pop && (fifo_q.cnt != '0)) begin
            fifo_d.rd  = fifo_q.rd + 1'b1;
            fifo_d.cnt = fifo_q.cnt - 1'b1;
            popped     = 1'b1;
        end
        if (push) begin
            if (flush || popped || (fifo_q.cnt != CNT_W'(DEPTH))) begin
                fifo_d.mem[fifo_q.wr] = push_vec;
                fifo_d.wr             = fifo_q.wr + 1'b1;
                fifo_d.cnt            = fifo_d.cnt + 1'b1;
            end else begin
                drop = 1'b1;
            end
        end
        fifo_d.busy = (fifo_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign head_vec = fifo_q.mem[fifo_q.rd];
    assign busy     = fifo_q.busy;

endmodule

// File: rtl/ipi_read_port.sv
module ipi_read_port
    import ipi_mailbox_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic                            we,
    input  logic [REG_ADDR_W-1:0]           addr,
    input  logic [CORE_ID_W-1:0]            core,
    input  logic [N_CORES-1:0][VEC_W-1:0]   heads,
    input  logic [N_CORES-1:0]              busy,
    input  logic [N_CORES-1:0]              drop,
    output logic [N_CORES-1:0]              pop,
    output logic [N_CORES-1:0]              flush,
    output logic                            rvalid,
    output logic [WORD_W-1:0]               rdata
);

    typedef struct packed {
        logic                rvalid;
        logic [WORD_W-1:0]   rdata;
        logic [N_CORES-1:0]  ovf;
    } rport_t;

    rport_t rp_d, rp_q;
    logic   recv_hit;

    assign recv_hit = req && (reg_sel_e'(addr) == REG_RECV);

    always_comb begin
        for (int i = 0; i < N_CORES; i++) begin
            pop[i]   = recv_hit && !we && (core == CORE_ID_W'(i));
            flush[i] = recv_hit &&  we && (core == CORE_ID_W'(i));
        end
    end

    always_comb begin
        rp_d        = rp_q;
        rp_d.rvalid = req && !we;
        rp_d.rdata  = '0;
        if (req && !we) begin
            unique case (reg_sel_e'(addr))
                REG_RECV: begin
                    for (int i = 0; i < N_CORES; i++) begin
                        if (pop[i] && busy[i]) rp_d.rdata = WORD_W'(heads[i]);
                    end
                end
                REG_OVF: begin
                    rp_d.rdata = WORD_W'(rp_q.ovf);
                    rp_d.ovf   = '0;
                end
                default: ;
            endcase
        end
        rp_d.ovf = rp_d.ovf | drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign rvalid = rp_q.rvalid;
    assign rdata  = rp_q.rdata;

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_mailbox_pkg::*;
#(
    parameter int N_CORES     = 4,
    parameter int QUEUE_DEPTH = 8,
    parameter int CORE_ID_W   = $clog2(N_CORES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic [CORE_ID_W-1:0]  bus_core,
    output logic                  bus_rvalid,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [N_CORES-1:0]    irq
);

    logic [N_CORES-1:0]            post_mask;
    logic [VEC_W-1:0]              post_vec;
    logic [N_CORES-1:0][VEC_W-1:0] heads;
    logic [N_CORES-1:0]            busy;
    logic [N_CORES-1:0]            drop;
    logic [N_CORES-1:0]            pop;
    logic [N_CORES-1:0]            flush;

    ipi_post_decode #(
        .N_CORES (N_CORES)
    ) post_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .push_mask (post_mask),
        .push_vec  (post_vec)
    );

    for (genvar g = 0; g < N_CORES; g++) begin : g_queue
        ipi_fifo #(
            .DEPTH (QUEUE_DEPTH)
        ) fifo_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (post_mask[g]),
            .push_vec (post_vec),
            .pop      (pop[g]),
            .flush    (flush[g]),
            .head_vec (heads[g]),
            .busy     (busy[g]),
            .drop     (drop[g])
        );
    end

    ipi_read_port #(
        .N_CORES   (N_CORES),
        .CORE_ID_W (CORE_ID_W)
    ) rport_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .core   (bus_core),
        .heads  (heads),
        .busy   (busy),
        .drop   (drop),
        .pop    (pop),
        .flush  (flush),
        .rvalid (bus_rvalid),
        .rdata  (bus_rdata)
    );

    assign irq = busy;

endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
    import ipi_mailbox_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int CORE_ID_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [CORE_ID_W-1:0]  bus_core,
    input logic                  bus_rvalid,
    input logic [WORD_W-1:0]     bus_rdata,
    input logic [N_CORES-1:0]    irq,
    input logic [N_CORES-1:0]    post_mask
);

    logic [N_CORES-1:0] recv_mask;
    logic [N_CORES-1:0] flush_mask;

    always_comb begin
        for (int i = 0; i < N_CORES; i++) begin
            recv_mask[i]  = bus_req && (reg_sel_e'(bus_addr) == REG_RECV)
                            && (bus_core == CORE_ID_W'(i));
            flush_mask[i] = recv_mask[i] && bus_we;
        end
    end

    // R5
    read_gets_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R1
    no_spurious_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    // R6
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (reg_sel_e'(bus_addr) == REG_RECV) && !irq[bus_core])
        |=> (bus_rdata == '0));

    // R10
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (reg_sel_e'(bus_addr) == REG_OVF))
        |=> ((bus_rdata >> N_CORES) == '0));

    // R7
    flush_drops_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flush_mask) & ~$past(post_mask) & irq) == '0));

    // R2
    line_rise_needs_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq) & ~$past(post_mask)) == '0));

    // R8
    line_fall_needs_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq & $past(irq) & ~$past(recv_mask)) == '0));

endmodule

bind ipi_mailbox ipi_mailbox_chk #(
    .N_CORES   (N_CORES),
    .CORE_ID_W (CORE_ID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_core   (bus_core),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .post_mask  (post_mask)
);

// File: tb/ipi_mailbox_tb_top.sv
`timescale 1ns/1ps
module ipi_mailbox_tb_top;

    localparam int NC    = 4;
    localparam int DEPTH = 8;
    localparam int CIDW  = 2;

    localparam logic [1:0] A_ONE    = 2'd0;
    localparam logic [1:0] A_EXCEPT = 2'd1;
    localparam logic [1:0] A_RECV   = 2'd2;
    localparam logic [1:0] A_OVF    = 2'd3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [CIDW-1:0] bus_core = '0;
    logic            bus_rvalid;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   irq;

    int checks = 0;
    int errors = 0;

    logic [15:0]   mq [NC][DEPTH];
    int            mc [NC];
    logic [NC-1:0] movf = '0;

    always #5 clk = ~clk;

    ipi_mailbox #(.N_CORES(NC), .QUEUE_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void m_push(int c, logic [15:0] v);
        if (mc[c] < DEPTH) begin
            mq[c][mc[c]] = v;
            mc[c]++;
        end else begin
            movf[c] = 1'b1;
        end
    endfunction

    function automatic logic [15:0] m_pop(int c);
        logic [15:0] v;
        if (mc[c] == 0) return 16'h0;
        v = mq[c][0];
        for (int j = 0; j < DEPTH - 1; j++) mq[c][j] = mq[c][j+1];
        mc[c]--;
        return v;
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] r = '0;
        for (int i = 0; i < NC; i++) r[i] = (mc[i] != 0);
        return r;
    endfunction

    task automatic bus_wr(logic [1:0] a, logic [31:0] d, int c);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        bus_core = CIDW'(c);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, int c, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_core = CIDW'(c);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        chk("R5 rvalid", 32'(bus_rvalid), 32'd1);
    endtask

    task automatic post(logic [1:0] a, logic [15:0] v, logic [15:0] tgt);
        for (int i = 0; i < NC; i++) begin
            if ((a == A_ONE && tgt == 16'(i)) || (a == A_EXCEPT && tgt != 16'(i)))
                m_push(i, v);
        end
        bus_wr(a, {v, tgt}, 0);
        @(negedge clk);
    endtask

    task automatic drain(string tag);
        logic [31:0] d;
        for (int i = 0; i < NC; i++) begin
            int n = mc[i] + 1;
            for (int k = 0; k < n; k++) begin
                bus_rd(A_RECV, i, d);
                chk(tag, d, {16'h0, m_pop(i)});
            end
        end
        chk("R8 lines low after drain", 32'(irq), 32'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NC; i++) mc[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        chk("R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int i = 0; i < NC; i++) begin
            bus_rd(A_RECV, i, d);
            chk("R1 R6 empty after reset", d, 32'h0);
        end

        // R2 / R5: send-one sweep, growing counts per core
        for (int t = 0; t < NC; t++) begin
            for (int k = 0; k <= t; k++) begin
                post(A_ONE, 16'((t + 1) << 8 | k), 16'(t));
                chk("R2 line after send-one", 32'(irq), exp_irq());
            end
        end
        drain("R5 fifo order");

        // R3 / R4: send-except over every named core and out-of-range names
        for (int x = 0; x < NC + 2; x++) begin
            logic [15:0] tg = (x == NC + 1) ? 16'hFFFF : 16'(x);
            post(A_EXCEPT, 16'h2000 + 16'(x), tg);
            chk("R3 R4 lines after send-except", 32'(irq), exp_irq());
        end
        drain("R3 except contents");

        // R4: send-one to a nonexistent core
        post(A_ONE, 16'h2F00, 16'd5);
        chk("R4 send-one out of range", 32'(irq), 32'h0);
        bus_rd(A_OVF, 0, d);
        chk("R4 no overflow", d, 32'h0);

        // R9 / R10: overflow on core 2
        for (int k = 0; k < DEPTH + 2; k++) post(A_ONE, 16'h3000 + 16'(k), 16'd2);
        chk("R9 line with full queue", 32'(irq), exp_irq());
        bus_rd(A_OVF, 1, d);
        chk("R10 overflow bits", d, {28'h0, movf});
        movf = '0;
        bus_rd(A_OVF, 1, d);
        chk("R10 overflow cleared", d, 32'h0);
        drain("R9 kept entries");

        // R7: flush core 1, core 0 untouched
        for (int k = 0; k < 3; k++) post(A_ONE, 16'h5100 + 16'(k), 16'd1);
        for (int k = 0; k < 2; k++) post(A_ONE, 16'h5000 + 16'(k), 16'd0);
        bus_wr(A_RECV, 32'h0, 1);
        mc[1] = 0;
        chk("R7 line after flush", 32'(irq), exp_irq());
        drain("R7 flush contents");

        // R11: post lands on full queue 3 in the cycle it is popped
        for (int k = 0; k < DEPTH; k++) post(A_ONE, 16'h4000 + 16'(k), 16'd3);
        bus_wr(A_ONE, {16'h4ABC, 16'd3}, 0);
        bus_rd(A_RECV, 3, d);
        chk("R11 pop with push", d, {16'h0, m_pop(3)});
        m_push(3, 16'h4ABC);
        @(negedge clk);
        bus_rd(A_OVF, 0, d);
        chk("R11 no overflow", d, 32'h0);
        drain("R11 contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule